// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

A 16-bit down counter runs at the block clock and never stops. Two input pins each feed a capture register of their own. When a pin shows the edge chosen for it, rising or falling, the value of the counter is copied into that pin's register. The capture does not pause or change the counter. Each pin must first pass through a synchronizer. Software reads the captured times whenever it likes. The difference between two captures gives the interval between the events.

Each channel has a sticky pending flag and an interrupt enable. When the counter passes from zero to all ones it sets a third pending flag for underflow. That flag has no enable of its own: it shares the enable of channel A. An interrupt caused by channel A can therefore come from a capture, an underflow or both, and software tells them apart by reading the flag register. All three flags are cleared by writing a one to them. A register port with a combinational read path carries every access.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset the counter holds 0xFFFF and falls by one on every clock. It is read at address 0, and a write to address 0 loads the written value in place of that clock's decrement.
- R2: A decrement from 0x0000 gives 0xFFFF and sets the underflow flag, which is bit 2 of the flag register at address 4.
- R3: A selected edge on pin A stores the counter value into capture register A (address 1). The edge is seen at the third rising clock after the pin changes, and the stored value is the count held just before that clock. The counter keeps decrementing.
- R4: Pin B works in the same way with capture register B (address 2), independently of pin A.
- R5: Control register bit 0 selects the edge for pin A and bit 1 selects it for pin B (0 = rising, 1 = falling). An edge of the other polarity neither captures nor sets a flag.
- R6: A capture on A sets flag bit 0 and a capture on B sets flag bit 1. Every flag stays set until it is cleared.
- R7: Writing to address 4 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. If a new event for a flag arrives in the same cycle as its clear, the flag stays set.
- R8: irq_o is high exactly when control bit 2 is set and flag 0 or flag 2 is set, or when control bit 3 is set and flag 1 is set.
- R9: A read of a capture register in the cycle in which it captures returns the previous value. The new value can be read from the next cycle on.
- R10: Reset clears the control register, the flags and both capture registers, and drives irq_o low.
- R11: The control register (address 3, bits 3:0) reads back as written. Writes to addresses 1 and 2 are ignored. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; the counter decrements once per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wr_i | input | 1 | Write strobe, taken at the rising clock |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i, combinational |
| pin_a_i | input | 1 | Asynchronous event input for channel A |
| pin_b_i | input | 1 | Asynchronous event input for channel B |
| irq_o | output | 1 | Interrupt request |

## Verification
The read port and irq_o are combinational. A register write appears one clock after the write strobe is taken, and a pin edge reaches its capture register and flag at the third rising clock after the pin changes. A behavioural model in the bench keeps a three-sample history of each pin. On every rising clock it advances the counter, the captures and the flags with the same latencies. On every falling clock it compares the read data and irq_o with the model. The directed steps change inputs just after a clock edge and read results one nanosecond later. They wait the exact number of edges each result needs, so the value before a capture and the value after it are both checked.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAP_A = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_B = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

  localparam int NUM_CH    = 2;
  localparam int NUM_FLAGS = NUM_CH + 1;
  localparam int FLAG_UF   = NUM_CH;
  // control layout: bit ch = falling-edge select, bit NUM_CH+ch = enable
  localparam int CTRL_W    = 2 * NUM_CH;
endpackage

// File: rtl/ct_rst_sync.sv
module ct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    last_d = level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign edge_o = fall_i ? (last_q & ~level) : (~last_q & level);

  // R5
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (!edge_o || (fall_i != $past(fall_i))));
endmodule

// File: rtl/ct_down_counter.sv
module ct_down_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign uf_o  = !load_i && (cnt_q == '0);

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q == $past(cnt_q) - ONE));
  // R1
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |=> (&cnt_q));
endmodule

// File: rtl/ct_capture_reg.sv
module ct_capture_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_q;
    if (cap_i) q_d = cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R3
  cap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (q_o == $past(cnt_i)));
  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/ct_sticky_flag.sv
module ct_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;

  always_comb begin
    q_d = set_i | (q_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  // R6
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  // R7
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import ct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  output logic              irq_o
);
  logic                 rst_n_q;
  logic [NUM_CH-1:0]    pins;
  logic [NUM_CH-1:0]    cap_evt;
  logic                 wr_cnt;
  logic                 wr_ctrl;
  logic                 wr_flags;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [CTRL_W-1:0]    ctrl_d;
  logic [CNT_W-1:0]     cnt;
  logic                 uf;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [CNT_W-1:0]     cap_q [NUM_CH];

  ct_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  assign pins     = {pin_b_i, pin_a_i};
  assign wr_cnt   = reg_wr_i && (reg_addr_i == A_COUNT);
  assign wr_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_flags = reg_wr_i && (reg_addr_i == A_FLAGS);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = reg_wdata_i[CTRL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  ct_down_counter #(.W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_q),
    .load_i     (wr_cnt),
    .load_val_i (reg_wdata_i),
    .cnt_o      (cnt),
    .uf_o       (uf)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ct_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_n_q),
      .pin_i  (pins[ch]),
      .fall_i (ctrl_q[ch]),
      .edge_o (cap_evt[ch])
    );

    ct_capture_reg #(.W(CNT_W)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_n_q),
      .cap_i  (cap_evt[ch]),
      .cnt_i  (cnt),
      .q_o    (cap_q[ch])
    );

    assign flag_set[ch] = cap_evt[ch];
  end

  assign flag_set[FLAG_UF] = uf;
  assign flag_clr = wr_flags ? reg_wdata_i[NUM_FLAGS-1:0] : '0;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    ct_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_n_q),
      .set_i  (flag_set[f]),
      .clr_i  (flag_clr[f]),
      .q_o    (flag_q[f])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_COUNT: reg_rdata_o = cnt;
      A_CAP_A: reg_rdata_o = cap_q[0];
      A_CAP_B: reg_rdata_o = cap_q[1];
      A_CTRL:  reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      A_FLAGS: reg_rdata_o[NUM_FLAGS-1:0] = flag_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (|(ctrl_q[CTRL_W-1:NUM_CH] & flag_q[NUM_CH-1:0]))
               | (ctrl_q[NUM_CH] & flag_q[FLAG_UF]);

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    irq_o |-> (flag_q != '0));
  // R11
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: tb/dual_capture_timer_bench.sv
`timescale 1ns/1ps
module dual_capture_timer_bench;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_capture_timer u_dual_capture_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (reg_addr),
    .reg_wr_i    (reg_wr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .pin_a_i     (pin_a),
    .pin_b_i     (pin_b),
    .irq_o       (irq)
  );

  // behavioural reference model
  logic [15:0] m_cnt = 16'hFFFF;
  logic [15:0] m_capa = '0;
  logic [15:0] m_capb = '0;
  logic [3:0]  m_ctrl = '0;
  logic [2:0]  m_pend = '0;
  logic [2:0]  ha = '0;
  logic [2:0]  hb = '0;
  int          act = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_capa = '0; m_capb = '0; m_ctrl = '0; m_pend = '0;
      ha = '0; hb = '0; act = 0;
    end else if (act < 2) begin
      act = act + 1;
    end else begin
      logic        ea, eb, load, uf;
      logic [15:0] now;
      logic [2:0]  clr;
      now  = m_cnt;
      ea   = m_ctrl[0] ? (!ha[1] && ha[2]) : (ha[1] && !ha[2]);
      eb   = m_ctrl[1] ? (!hb[1] && hb[2]) : (hb[1] && !hb[2]);
      if (ea) m_capa = now;
      if (eb) m_capb = now;
      load = reg_wr && (reg_addr == 3'd0);
      uf   = !load && (now == 16'h0000);
      m_cnt = load ? reg_wdata : now - 16'd1;
      clr  = (reg_wr && reg_addr == 3'd4) ? reg_wdata[2:0] : 3'b000;
      m_pend = (m_pend & ~clr) | {uf, eb, ea};
      if (reg_wr && reg_addr == 3'd3) m_ctrl = reg_wdata[3:0];
      ha = {ha[1:0], pin_a};
      hb = {hb[1:0], pin_b};
    end
  end

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0:    return m_cnt;
      3'd1:    return m_capa;
      3'd2:    return m_capb;
      3'd3:    return {12'b0, m_ctrl};
      3'd4:    return {13'b0, m_pend};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic model_irq();
    return (m_ctrl[2] && (m_pend[0] || m_pend[2])) || (m_ctrl[3] && m_pend[1]);
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0:    return "R1 count";
      3'd1:    return "R3 capture A";
      3'd2:    return "R4 capture B";
      3'd3:    return "R11 control";
      3'd4:    return "R6 flags";
      default: return "R11 unmapped";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act_v, input logic [15:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    chk(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
    chk("R8 irq vs model", {15'b0, irq}, {15'b0, model_irq()});
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [15:0] exp_v, input string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp_v);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    peek(3'd3, 16'h0000, "R10 control after reset");
    peek(3'd4, 16'h0000, "R10 flags after reset");
    peek(3'd1, 16'h0000, "R10 capture A after reset");
    peek(3'd2, 16'h0000, "R10 capture B after reset");
    chk("R10 irq after reset", {15'b0, irq}, 16'h0000);

    // R1 load and decrement
    wr(3'd0, 16'h0010);
    peek(3'd0, 16'h0010, "R1 load value");
    @(posedge clk); #2;
    peek(3'd0, 16'h000F, "R1 decrement");

    // R2 underflow, R8 shared enable
    wr(3'd0, 16'h0002);
    repeat (3) @(posedge clk);
    #1;
    peek(3'd0, 16'hFFFF, "R2 wrap to all ones");
    peek(3'd4, 16'h0004, "R2 underflow flag");
    chk("R8 irq low without enable", {15'b0, irq}, 16'h0000);
    wr(3'd3, 16'h0004);
    #1 chk("R8 underflow irq via enable A", {15'b0, irq}, 16'h0001);
    wr(3'd4, 16'h0000);
    peek(3'd4, 16'h0004, "R7 zero write keeps flag");
    wr(3'd4, 16'h0004);
    peek(3'd4, 16'h0000, "R7 clear underflow");
    chk("R8 irq drops after clear", {15'b0, irq}, 16'h0000);
    wr(3'd3, 16'h0000);

    // R3 rising capture on A with R9 old-value read
    wr(3'd0, 16'h1000);
    pin_a = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    peek(3'd1, 16'h0000, "R9 old value before capture");
    @(posedge clk);
    #1;
    peek(3'd1, 16'h0FFE, "R3 captured count");
    peek(3'd0, 16'h0FFD, "R3 counter keeps running");
    peek(3'd4, 16'h0001, "R6 flag A set");
    wr(3'd1, 16'hABCD);
    peek(3'd1, 16'h0FFE, "R11 write to capture ignored");
    repeat (4) @(posedge clk);
    #1 peek(3'd4, 16'h0001, "R6 flag A sticky");

    // R5 falling edge ignored on A
    wr(3'd4, 16'h0007);
    pin_a = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    peek(3'd1, 16'h0FFE, "R5 wrong edge no capture");
    peek(3'd4, 16'h0000, "R5 wrong edge no flag");

    // R4/R5 falling select on B with enable B
    wr(3'd3, 16'h000A);
    peek(3'd3, 16'h000A, "R11 control readback");
    pin_b = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    peek(3'd2, 16'h0000, "R5 rising ignored on B");
    chk("R8 no irq from ignored edge", {15'b0, irq}, 16'h0000);
    wr(3'd0, 16'h2000);
    pin_b = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    peek(3'd2, 16'h1FFE, "R4 capture B on falling");
    peek(3'd4, 16'h0002, "R6 flag B set");
    chk("R8 irq from B", {15'b0, irq}, 16'h0001);
    wr(3'd4, 16'h0002);
    chk("R7 irq drops after B clear", {15'b0, irq}, 16'h0000);

    // R7 event wins over same-cycle clear
    wr(3'd3, 16'h0000);
    @(negedge clk); #1 pin_a = 1'b1;
    @(negedge clk); #1;
    @(negedge clk); #1 reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0001;
    @(negedge clk); #1 reg_wr = 1'b0;
    peek(3'd4, 16'h0001, "R7 event beats clear");
    peek(3'd5, 16'h0000, "R11 unmapped reads zero");

    // mixed traffic, compared by the model every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(0, 5) == 0) pin_a = ~pin_a;
      if ($urandom_range(0, 5) == 0) pin_b = ~pin_b;
      reg_addr  = 3'($urandom_range(0, 7));
      reg_wr    = ($urandom_range(0, 15) == 0);
      reg_wdata = 16'($urandom);
    end
    @(negedge clk); #1 reg_wr = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule